// File: doc/BRIEF.md
# Hint-Guided Branch Direction Predictor

This block decides whether a conditional branch is expected to be taken. Every branch carries a 2-bit hint chosen by the compiler. A static hint fixes the answer outright. A dynamic hint hands the decision to a table of 2-bit saturating counters. The table is indexed by a slice of the branch address. Until an entry has been trained, a dynamic lookup falls back to the direction named in the hint.

The front end presents a branch address and its hint on the lookup port and reads back a direction in the same cycle. When the branch resolves, the outcome is presented on the update port together with the same address and hint. Dynamic-hinted outcomes train the table. Static-hinted outcomes are dropped.

Top module: `bp_hint_predictor`

## Requirements
- R1: Hint encoding is 00 static-taken, 01 static-not-taken, 10 dynamic-taken, 11 dynamic-not-taken. A lookup with hint 00 always predicts taken and with hint 01 always predicts not taken, whatever the table holds.
- R2: A dynamic lookup (hint 10 or 11) whose table entry is not valid predicts the hinted direction: taken for 10, not taken for 11.
- R3: A dynamic lookup whose entry is valid predicts taken exactly when the entry's counter is 2 or 3. The direction part of the hint is then ignored.
- R4: The table has 256 entries. The entry index is address bits [11:4], so two addresses that agree in those bits share one entry.
- R5: A dynamic update to an entry that is not valid writes counter 2 if the outcome was taken and 1 if it was not taken, and marks the entry valid.
- R6: A dynamic update to a valid entry increments the counter on taken and decrements it on not taken, saturating at 3 and at 0.
- R7: An update carrying a static hint (00 or 01) leaves the table unchanged.
- R8: An update takes effect at the next rising clock edge. A lookup in the same cycle to the same index sees the value held before the update.
- R9: Synchronous active-high reset marks every entry not valid. Updates are ignored while reset is high.
- R10: With the update enable low, the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Address of the branch being predicted |
| lk_hint | input | 2 | Hint of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| up_en | input | 1 | Update request for this cycle |
| up_addr | input | 32 | Address of the resolved branch |
| up_hint | input | 2 | Hint of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest case to reach is a counter that sits at a saturation limit and is then driven against it. Such a counter also has to be reached through an address that aliases a differently hinted branch, while a static update and a same-cycle lookup land on the same index. Random traffic rarely sets this up. The random phase therefore draws addresses from a small pool of indices with random upper and lower bits, which forces aliasing and repeated training. Directed sequences walk one entry to 3 and to 0 and push past each limit. They also issue static updates and same-cycle read-after-write on a trained entry, and a mid-run reset after the table has filled.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MIN     = ctr_t'(0);
    localparam ctr_t CTR_MAX     = ctr_t'((1 << CTR_W) - 1);
    localparam ctr_t CTR_WEAK_T  = ctr_t'(1 << (CTR_W - 1));
    localparam ctr_t CTR_WEAK_NT = ctr_t'((1 << (CTR_W - 1)) - 1);

    // bit 1: source (0 fixed, 1 table); bit 0: direction (0 taken, 1 not taken)
    typedef enum logic [1:0] {
        HINT_FIX_T  = 2'b00,
        HINT_FIX_NT = 2'b01,
        HINT_DYN_T  = 2'b10,
        HINT_DYN_NT = 2'b11
    } hint_e;

    typedef struct packed {
        logic dyn;
        logic dir;
    } hint_info_t;

    typedef struct packed {
        logic vld;
        ctr_t cnt;
    } entry_t;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
        end else begin
            nxt = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
        end
        return nxt;
    endfunction

    function automatic ctr_t ctr_seed(input logic taken);
        return taken ? CTR_WEAK_T : CTR_WEAK_NT;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[CTR_W-1];
    endfunction

endpackage

// File: rtl/bp_hint_decode.sv
module bp_hint_decode
    import bp_pkg::*;
(
    input  logic [1:0] hint,
    output hint_info_t info
);
    hint_e h;

    always_comb begin
        h = hint_e'(hint);
        unique case (h)
            HINT_FIX_T:  info = '{dyn: 1'b0, dir: 1'b1};
            HINT_FIX_NT: info = '{dyn: 1'b0, dir: 1'b0};
            HINT_DYN_T:  info = '{dyn: 1'b1, dir: 1'b1};
            HINT_DYN_NT: info = '{dyn: 1'b1, dir: 1'b0};
            default:     info = '{dyn: 1'b0, dir: 1'b0};
        endcase
    end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int NRD   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx [NRD],
    output entry_t           rd_ent [NRD],
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_t             wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t             cnt_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            cnt_q[wr_idx] <= wr_val;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_ent[p].vld = vld_q[rd_idx[p]];
            rd_ent[p].cnt = cnt_q[rd_idx[p]];
        end
    end

    // R5
    first_write_weak_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !vld_q[wr_idx]) |-> (wr_val == CTR_WEAK_T || wr_val == CTR_WEAK_NT));

    // R6
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && vld_q[wr_idx]) |->
            (wr_val == cnt_q[wr_idx] || wr_val == cnt_q[wr_idx] + ctr_t'(1)
             || wr_val == cnt_q[wr_idx] - ctr_t'(1)));

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld_q[$past(wr_idx)] && cnt_q[$past(wr_idx)] == $past(wr_val)));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (vld_q == '0));

endmodule

// File: rtl/bp_train.sv
module bp_train
    import bp_pkg::*;
(
    input  logic       up_en,
    input  hint_info_t up_info,
    input  logic       up_taken,
    input  entry_t     cur,
    output logic       wr_en,
    output ctr_t       wr_val
);
    always_comb begin
        wr_en  = up_en && up_info.dyn;
        wr_val = cur.vld ? ctr_step(cur.cnt, up_taken) : ctr_seed(up_taken);
    end
endmodule

// File: rtl/bp_hint_predictor.sv
module bp_hint_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 8,
    parameter int IDX_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [1:0]        lk_hint,
    output logic              lk_taken,
    input  logic              up_en,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_hint,
    input  logic              up_taken
);
    localparam int PORT_LK = 0;
    localparam int PORT_UP = 1;
    localparam int NRD     = 2;

    hint_info_t       lk_info;
    hint_info_t       up_info;
    logic [IDX_W-1:0] rd_idx [NRD];
    entry_t           rd_ent [NRD];
    logic             wr_en;
    ctr_t             wr_val;

    bp_hint_decode u_lk_dec (.hint(lk_hint), .info(lk_info));
    bp_hint_decode u_up_dec (.hint(up_hint), .info(up_info));

    always_comb begin
        rd_idx[PORT_LK] = lk_addr[IDX_LSB +: IDX_W];
        rd_idx[PORT_UP] = up_addr[IDX_LSB +: IDX_W];
    end

    bp_ctr_table #(.IDX_W(IDX_W), .NRD(NRD)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_idx),
        .rd_ent (rd_ent),
        .wr_en  (wr_en),
        .wr_idx (rd_idx[PORT_UP]),
        .wr_val (wr_val)
    );

    bp_train u_train (
        .up_en    (up_en),
        .up_info  (up_info),
        .up_taken (up_taken),
        .cur      (rd_ent[PORT_UP]),
        .wr_en    (wr_en),
        .wr_val   (wr_val)
    );

    always_comb begin
        if (lk_info.dyn && rd_ent[PORT_LK].vld) begin
            lk_taken = ctr_says_taken(rd_ent[PORT_LK].cnt);
        end else begin
            lk_taken = lk_info.dir;
        end
    end

    // R7
    static_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (up_en && !up_hint[1]) |-> !wr_en);

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !up_en |-> !wr_en);

    // R1
    static_pred_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hint[1] |-> (lk_taken == !lk_hint[0]));

endmodule

// File: tb/sim_bp_hint_predictor.sv
`timescale 1ns/1ps
module sim_bp_hint_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_hint = '0;
    logic        lk_taken;
    logic        up_en = 1'b0;
    logic [31:0] up_addr = '0;
    logic [1:0]  up_hint = '0;
    logic        up_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] m_cnt [256];
    logic       m_vld [256];

    always #5 clk = ~clk;

    bp_hint_predictor u0 (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_hint(lk_hint), .lk_taken(lk_taken),
        .up_en(up_en), .up_addr(up_addr), .up_hint(up_hint), .up_taken(up_taken)
    );

    function automatic int idx_of(input logic [31:0] a);
        return int'(a[11:4]);
    endfunction

    function automatic logic model_pred(input logic [31:0] a, input logic [1:0] h);
        int i = idx_of(a);
        if (!h[1]) return ~h[0];
        if (!m_vld[i]) return ~h[0];
        return m_cnt[i][1];
    endfunction

    function automatic void model_upd(input logic e, input logic [31:0] a,
                                      input logic [1:0] h, input logic t);
        int i = idx_of(a);
        if (!e || !h[1]) return;
        if (!m_vld[i]) begin
            m_cnt[i] = t ? 2'd2 : 2'd1;
            m_vld[i] = 1'b1;
        end else if (t) begin
            if (m_cnt[i] != 2'd3) m_cnt[i] = m_cnt[i] + 2'd1;
        end else begin
            if (m_cnt[i] != 2'd0) m_cnt[i] = m_cnt[i] - 2'd1;
        end
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s lk_taken actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational lookup, model the edge.
    task automatic step(input logic [31:0] la, input logic [1:0] lh,
                        input logic ue, input logic [31:0] ua,
                        input logic [1:0] uh, input logic ut, input string tag);
        @(negedge clk);
        lk_addr = la; lk_hint = lh;
        up_en = ue; up_addr = ua; up_hint = uh; up_taken = ut;
        #1;
        chk(lk_taken, model_pred(la, lh), tag);
        @(posedge clk);
        if (!rst) model_upd(ue, ua, uh, ut);
    endtask

    task automatic look(input logic [31:0] la, input logic [1:0] lh, input string tag);
        step(la, lh, 1'b0, 32'h0, 2'b10, 1'b0, tag);
    endtask

    task automatic train(input logic [31:0] ua, input logic [1:0] uh, input logic ut);
        step(ua, 2'b10, 1'b1, ua, uh, ut, "R6");
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a_sat;
        logic [31:0] a_alias;
        void'($urandom(32'd7741));
        model_clear();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 / R2: after reset every dynamic lookup follows the hint
        look(32'h0000_0000, 2'b10, "R9");
        look(32'h0000_0FF0, 2'b11, "R9");
        look(32'h0000_0550, 2'b10, "R2");
        // R1: static lookups on an empty table
        look(32'h0000_0550, 2'b00, "R1");
        look(32'h0000_0550, 2'b01, "R1");

        // R5: first update seeds weak value; checked through R3 lookups
        a_sat = 32'h0000_0230;
        step(a_sat, 2'b11, 1'b1, a_sat, 2'b10, 1'b1, "R8");   // same-cycle sees old
        look(a_sat, 2'b11, "R5");                              // weak taken -> taken
        chk(lk_taken, 1'b1, "R3");
        // R6: saturate high then one step down stays taken
        train(a_sat, 2'b11, 1'b1);
        train(a_sat, 2'b10, 1'b1);
        train(a_sat, 2'b10, 1'b1);
        train(a_sat, 2'b11, 1'b0);
        look(a_sat, 2'b11, "R6");
        chk(lk_taken, 1'b1, "R6");
        train(a_sat, 2'b10, 1'b0);
        look(a_sat, 2'b10, "R6");
        chk(lk_taken, 1'b0, "R6");
        // R6: saturate low then one taken stays not-taken
        train(a_sat, 2'b10, 1'b0);
        train(a_sat, 2'b10, 1'b0);
        train(a_sat, 2'b10, 1'b1);
        look(a_sat, 2'b10, "R6");
        chk(lk_taken, 1'b0, "R6");

        // R7: static updates do not train the entry (counter 1)
        for (int k = 0; k < 4; k++) step(a_sat, 2'b10, 1'b1, a_sat, 2'b00, 1'b1, "R7");
        look(a_sat, 2'b10, "R7");
        chk(lk_taken, 1'b0, "R7");
        // R10: enable low does not train
        for (int k = 0; k < 4; k++) step(a_sat, 2'b10, 1'b0, a_sat, 2'b10, 1'b1, "R10");
        look(a_sat, 2'b10, "R10");
        chk(lk_taken, 1'b0, "R10");

        // R4: aliasing address shares the entry
        a_alias = 32'hABCD_E23F;
        look(a_alias, 2'b10, "R4");
        chk(lk_taken, 1'b0, "R4");
        train(a_alias, 2'b11, 1'b1);
        look(a_sat, 2'b11, "R4");
        chk(lk_taken, 1'b1, "R4");
        look(32'h0000_0240, 2'b10, "R4");

        // R8: same-cycle lookup during update sees old value (counter 2 -> 1)
        step(a_sat, 2'b10, 1'b1, a_sat, 2'b11, 1'b0, "R8");
        look(a_sat, 2'b10, "R8");

        // Random phase with aliasing pool
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] la, ua;
            logic [3:0] li, ui;
            la = $urandom; ua = $urandom;
            li = 4'($urandom_range(0, 15)); ui = 4'($urandom_range(0, 15));
            la[11:4] = {4'h3, li};
            ua[11:4] = {4'h3, ui};
            if (($urandom % 4) == 0) ua[11:4] = la[11:4];
            step(la, 2'($urandom), 1'($urandom % 3 != 0), ua, 2'($urandom),
                 1'($urandom), "R3");
        end

        // R9: mid-run reset invalidates trained entries
        @(negedge clk);
        rst = 1'b1;
        up_en = 1'b1; up_addr = 32'h0000_0300; up_hint = 2'b10; up_taken = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        up_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            look({20'h0, 4'h3, 4'(i), 4'h0}, 2'b11, "R9");
            look({20'h0, 4'h3, 4'(i), 4'h0}, 2'b10, "R9");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule